// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital control for a successive-approximation converter. It works in units of the conversion period, marked by a one-clock enable `tad_tick`. A start comes from a software set pulse or from a qualified compare-unit event trigger. Either one sets the busy bit. On the next period the block runs an automatic acquisition window of a selectable length, or none at all. It then spends one period disconnecting the hold capacitor and resolves the code one bit per period, most significant bit first. It does this by presenting a trial code to an external DAC and reading back a comparator bit.

On completion the result is stored right-justified across a byte pair. In the same clock edge the busy bit drops, the interrupt flag rises and the hold capacitor reconnects. Software may abort by clearing busy. An abort leaves the stored result untouched. A fixed recovery wait follows every conversion, whether it completed or was aborted. A start that arrives during the wait is kept and acted on as soon as the wait ends.

Top module: `adc_sar_seq`

## Requirements
- R1: After reset, busy, irq_flag, timer_rst and both result bytes read 0, and hold_conn reads 1.
- R2: The acquisition select codes 0 through 7 give 0, 2, 4, 6, 8, 12, 16 and 20 periods of acquisition. A start requested while idle drops busy on the tick numbered 12 + that length, counted from the request.
- R3: hold_conn is 0 for the whole conversion. On the tick after entry into conversion, sar_trial holds only its top bit. Lower bits are tried one per tick after that.
- R4: At completion, in a single clock edge, the result takes the code resolved from cmp_in, busy goes to 0, irq_flag goes to 1 and hold_conn goes to 1.
- R5: result_lo carries result bits 7..0. result_hi carries result bits 9..8 in its bits 1..0, and its bits 7..2 read 0.
- R6: A go_clr pulse during acquisition or conversion aborts the run. Busy goes to 0 and hold_conn goes to 1 on the next edge. The result and irq_flag are left unchanged.
- R7: After a completion or an abort, 2 ticks must pass before a new acquisition or conversion can begin. A start that arrives during this wait is held and begins on the second tick.
- R8: A res_wr pulse loads res_wr_data into the result while the block is idle or recovering. The pulse is ignored during acquisition and conversion.
- R9: A trig_evt pulse sets busy only when mode_sel equals 4'b1011 and enable is 1.
- R10: Every trig_evt pulse produces a one-clock timer_rst pulse on the next edge, whatever mode_sel and enable are.
- R11: go_set has no effect while enable is 0.
- R12: irq_clr clears irq_flag. A completion in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tad_tick | input | 1 | One-clock pulse per conversion period |
| enable | input | 1 | Converter enabled |
| acq_sel | input | 3 | Acquisition length code |
| go_set | input | 1 | Software start pulse |
| go_clr | input | 1 | Software clear / abort pulse |
| trig_evt | input | 1 | Compare-unit event pulse |
| mode_sel | input | 4 | Compare-unit mode field |
| cmp_in | input | 1 | Comparator: input at or above trial code |
| res_wr | input | 1 | Software result write strobe |
| res_wr_data | input | 10 | Software result write value |
| irq_clr | input | 1 | Clear interrupt flag |
| busy | output | 1 | Start/busy status bit |
| hold_conn | output | 1 | Hold capacitor connected to input |
| sar_trial | output | 10 | Trial code to the DAC |
| result_hi | output | 8 | Result high byte |
| result_lo | output | 8 | Result low byte |
| irq_flag | output | 1 | Conversion-complete flag |
| timer_rst | output | 1 | Reset pulse to the associated timer |

## Verification
The bench builds the block with its default parameters: 10-bit resolution, 8-bit result bytes, trigger code 4'b1011 and a 2-period recovery wait. Its comparator model compares a fixed analog value against sar_trial. With these settings it can run every one of the eight acquisition codes, reach the full-scale and zero codes, and place starts, writes and aborts in each of the four sequencer phases.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int SEL_W = 3;
  localparam int ACQ_W = 5;

  typedef enum logic [1:0] {S_IDLE, S_ACQ, S_CONV, S_RECOV} seq_state_t;

  // Acquisition length in conversion periods: codes 0-3 step by 2, codes 4-7 step by 4 from 8.
  function automatic logic [ACQ_W-1:0] acq_tads(input logic [SEL_W-1:0] code);
    if (code[2]) return ACQ_W'(8) + {1'b0, code[1:0], 2'b00};
    else         return {2'b00, code[1:0], 1'b0};
  endfunction
endpackage

// File: rtl/adc_tad_cnt.sv
module adc_tad_cnt #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             advance,
  input  logic             cmp_in,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] resolved,
  output logic             last
);
  localparam int PW = $clog2(RES_W + 1);
  localparam logic [PW-1:0] POS_DISC = PW'(RES_W);

  logic [PW-1:0]    pos;
  logic [RES_W-1:0] nxt;

  // Bit under test takes the comparator decision; the next lower bit is then tried.
  always_comb begin
    resolved = trial;
    for (int i = 0; i < RES_W; i++)
      if (PW'(i) == pos) resolved[i] = cmp_in;
    nxt = resolved;
    for (int i = 0; i < RES_W; i++)
      if (PW'(i + 1) == pos) nxt[i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      trial <= '0;
      pos   <= POS_DISC;
    end else if (advance) begin
      if (pos == POS_DISC) begin
        trial[RES_W-1] <= 1'b1;
        pos            <= PW'(RES_W - 1);
      end else begin
        trial <= nxt;
        if (pos != '0) pos <= pos - 1'b1;
      end
    end
  end

  assign last = (pos == '0);

  assert_msb_first_R3: assert property (@(posedge clk) disable iff (rst)
    (advance && !start && pos == POS_DISC) |=> ($countones(trial) == 1 && trial[RES_W-1]));
endmodule

// File: rtl/adc_trig_gate.sv
module adc_trig_gate #(
  parameter int               MODE_W    = 4,
  parameter logic [MODE_W-1:0] TRIG_CODE = 4'b1011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_evt,
  input  logic              enable,
  input  logic [MODE_W-1:0] mode_sel,
  output logic              start_req,
  output logic              timer_rst
);
  assign start_req = trig_evt && enable && (mode_sel == TRIG_CODE);

  always_ff @(posedge clk) begin
    if (rst) timer_rst <= 1'b0;
    else     timer_rst <= trig_evt;
  end

  assert_timer_rst_R10: assert property (@(posedge clk) disable iff (rst)
    trig_evt |=> timer_rst);
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
  import adc_seq_pkg::*;
#(
  parameter int               RES_W     = 10,
  parameter int               BYTE_W    = 8,
  parameter int               MODE_W    = 4,
  parameter logic [MODE_W-1:0] TRIG_CODE = 4'b1011,
  parameter int               RECOV_TAD = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tad_tick,
  input  logic              enable,
  input  logic [SEL_W-1:0]  acq_sel,
  input  logic              go_set,
  input  logic              go_clr,
  input  logic              trig_evt,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              cmp_in,
  input  logic              res_wr,
  input  logic [RES_W-1:0]  res_wr_data,
  input  logic              irq_clr,
  output logic              busy,
  output logic              hold_conn,
  output logic [RES_W-1:0]  sar_trial,
  output logic [BYTE_W-1:0] result_hi,
  output logic [BYTE_W-1:0] result_lo,
  output logic              irq_flag,
  output logic              timer_rst
);
  localparam int HI_PAD = 2 * BYTE_W - RES_W;
  localparam logic [ACQ_W-1:0] RECOV_LOAD = ACQ_W'(RECOV_TAD - 1);

  seq_state_t       state, state_n;
  logic [RES_W-1:0] result_q, sar_resolved;
  logic [ACQ_W-1:0] cnt_val, acq_n;
  logic             cnt_load, cnt_zero, sar_start, sar_adv, sar_last;
  logic             done, abort, begin_ok, trig_start, set_req, active;

  adc_trig_gate #(.MODE_W(MODE_W), .TRIG_CODE(TRIG_CODE)) u_trig (
    .clk(clk), .rst(rst), .trig_evt(trig_evt), .enable(enable),
    .mode_sel(mode_sel), .start_req(trig_start), .timer_rst(timer_rst));

  adc_tad_cnt #(.W(ACQ_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tad_tick), .load(cnt_load),
    .load_val(cnt_val), .zero(cnt_zero));

  adc_sar_reg #(.RES_W(RES_W)) u_sar (
    .clk(clk), .rst(rst), .start(sar_start), .advance(sar_adv),
    .cmp_in(cmp_in), .trial(sar_trial), .resolved(sar_resolved), .last(sar_last));

  assign set_req = (go_set && enable) || trig_start;
  assign active  = (state == S_ACQ) || (state == S_CONV);

  always_comb begin
    state_n   = state;
    cnt_load  = 1'b0;
    cnt_val   = '0;
    sar_start = 1'b0;
    sar_adv   = 1'b0;
    done      = 1'b0;
    abort     = 1'b0;
    begin_ok  = 1'b0;
    acq_n     = acq_tads(acq_sel);
    case (state)
      S_IDLE:  if (tad_tick && busy && !go_clr) begin_ok = 1'b1;
      S_ACQ:   if (go_clr) abort = 1'b1;
               else if (tad_tick && cnt_zero) begin
                 state_n   = S_CONV;
                 sar_start = 1'b1;
               end
      S_CONV:  if (go_clr) abort = 1'b1;
               else if (tad_tick) begin
                 sar_adv = 1'b1;
                 done    = sar_last;
               end
      S_RECOV: if (tad_tick && cnt_zero) begin
                 if (busy && !go_clr) begin_ok = 1'b1;
                 else                 state_n  = S_IDLE;
               end
      default: state_n = S_IDLE;
    endcase
    if (begin_ok) begin
      if (acq_n == '0) begin
        state_n   = S_CONV;
        sar_start = 1'b1;
      end else begin
        state_n  = S_ACQ;
        cnt_load = 1'b1;
        cnt_val  = acq_n - 1'b1;
      end
    end
    if (abort || done) begin
      state_n  = S_RECOV;
      cnt_load = 1'b1;
      cnt_val  = RECOV_LOAD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      busy     <= 1'b0;
      result_q <= '0;
      irq_flag <= 1'b0;
    end else begin
      state <= state_n;
      if (set_req)        busy <= 1'b1;
      if (go_clr || done) busy <= 1'b0;
      if (done)                    result_q <= sar_resolved;
      else if (res_wr && !active)  result_q <= res_wr_data;
      if (done)         irq_flag <= 1'b1;
      else if (irq_clr) irq_flag <= 1'b0;
    end
  end

  assign hold_conn = (state != S_CONV);
  assign result_lo = result_q[BYTE_W-1:0];
  assign result_hi = {{HI_PAD{1'b0}}, result_q[RES_W-1:BYTE_W]};

  assert_done_flags_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flag) |-> ($fell(busy) && $rose(hold_conn)));

  assert_abort_keeps_R6: assert property (@(posedge clk) disable iff (rst)
    (state == S_CONV && go_clr) |=> ($stable(result_q) && !busy && hold_conn));

  assert_recov_wait_R7: assert property (@(posedge clk) disable iff (rst)
    (state == S_RECOV && !cnt_zero) |=> (state == S_RECOV));

  assert_wr_block_R8: assert property (@(posedge clk) disable iff (rst)
    (state == S_ACQ && res_wr) |=> $stable(result_q));

  // R9 and R11: with the converter disabled, nothing can raise busy.
  assert_disabled_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (!enable && !busy) |=> !busy);
endmodule

// File: tb/adc_sar_seq_bench.sv
`timescale 1ns/1ps
module adc_sar_seq_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic tad_tick = 0, enable = 0, go_set = 0, go_clr = 0, trig_evt = 0;
  logic res_wr = 0, irq_clr = 0;
  logic [2:0] acq_sel = 0;
  logic [3:0] mode_sel = 0;
  logic [9:0] res_wr_data = 0, vin = 0;
  logic cmp_in;
  logic busy, hold_conn, irq_flag, timer_rst;
  logic [9:0] sar_trial;
  logic [7:0] result_hi, result_lo;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;
  assign cmp_in = (vin >= sar_trial);

  adc_sar_seq u_adc_sar_seq (
    .clk(clk), .rst(rst), .tad_tick(tad_tick), .enable(enable), .acq_sel(acq_sel),
    .go_set(go_set), .go_clr(go_clr), .trig_evt(trig_evt), .mode_sel(mode_sel),
    .cmp_in(cmp_in), .res_wr(res_wr), .res_wr_data(res_wr_data), .irq_clr(irq_clr),
    .busy(busy), .hold_conn(hold_conn), .sar_trial(sar_trial), .result_hi(result_hi),
    .result_lo(result_lo), .irq_flag(irq_flag), .timer_rst(timer_rst));

  // {acq_sel, analog value}
  localparam logic [12:0] VEC [0:7] = '{
    {3'd0, 10'h000}, {3'd1, 10'h3FF}, {3'd2, 10'h155}, {3'd3, 10'h2AA},
    {3'd4, 10'h001}, {3'd5, 10'h200}, {3'd6, 10'h1FF}, {3'd7, 10'h0C3}};

  function automatic int acq_len(input logic [2:0] c);
    case (c)
      3'd0: return 0;  3'd1: return 2;  3'd2: return 4;  3'd3: return 6;
      3'd4: return 8;  3'd5: return 12; 3'd6: return 16; default: return 20;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick1();
    @(negedge clk) tad_tick = 1;
    @(negedge clk) tad_tick = 0;
    @(negedge clk);
  endtask

  task automatic pulse_go();  @(negedge clk) go_set = 1; @(negedge clk) go_set = 0; endtask
  task automatic pulse_clr(); @(negedge clk) go_clr = 1; @(negedge clk) go_clr = 0; endtask
  task automatic pulse_irqclr(); @(negedge clk) irq_clr = 1; @(negedge clk) irq_clr = 0; endtask
  task automatic pulse_wr(input logic [9:0] d);
    @(negedge clk) begin res_wr = 1; res_wr_data = d; end
    @(negedge clk) res_wr = 0;
  endtask
  task automatic pulse_trig(); @(negedge clk) trig_evt = 1; @(negedge clk) trig_evt = 0; endtask

  task automatic ticks_to_done(output int n);
    n = 0;
    for (int k = 0; k < 60; k++) begin
      tick1();
      n++;
      if (!busy) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 irq", irq_flag, 0);
    chk("R1 hold", hold_conn, 1);
    chk("R1 timer_rst", timer_rst, 0);
    chk("R1 result", {result_hi, result_lo}, 0);
    enable = 1;

    // Table: R2 timing per code, R4/R5 result and flags
    for (int v = 0; v < 8; v++) begin
      acq_sel = VEC[v][12:10];
      vin     = VEC[v][9:0];
      pulse_go();
      ticks_to_done(n);
      chk("R2 ticks to done", n, 12 + acq_len(acq_sel));
      chk("R4 result_lo", result_lo, {24'd0, vin[7:0]});
      chk("R5 result_hi", result_hi, {30'd0, vin[9:8]});
      chk("R4 irq set", irq_flag, 1);
      chk("R4 hold reconnected", hold_conn, 1);
      pulse_irqclr();
      chk("R12 irq cleared", irq_flag, 0);
      repeat (3) tick1();
    end

    // R7 pending start during recovery, R3 hold and MSB-first
    acq_sel = 0; vin = 10'h2C5;
    pulse_go();
    ticks_to_done(n);
    chk("R2 ticks code0", n, 12);
    pulse_go();
    tick1();
    chk("R7 still recovering hold", hold_conn, 1);
    chk("R7 start held", busy, 1);
    tick1();
    chk("R7 conversion begins after wait", hold_conn, 0);
    tick1();
    chk("R3 msb trial", sar_trial, 10'h200);
    chk("R3 hold open", hold_conn, 0);
    ticks_to_done(n);
    chk("R3 remaining bit ticks", n, 10);
    chk("R4 result second run", {result_hi[1:0], result_lo}, 10'h2C5);
    pulse_irqclr();
    repeat (3) tick1();

    // R8 write when idle, ignored while converting; R6 abort keeps it
    pulse_wr(10'h2AB);
    chk("R8 write hi", result_hi, 8'h02);
    chk("R8 write lo", result_lo, 8'hAB);
    vin = 10'h0F0;
    pulse_go();
    tick1();
    tick1();
    pulse_wr(10'h011);
    chk("R8 write ignored in conversion", {result_hi[1:0], result_lo}, 10'h2AB);
    pulse_clr();
    chk("R6 busy cleared", busy, 0);
    chk("R6 hold reconnected", hold_conn, 1);
    chk("R6 result kept", {result_hi[1:0], result_lo}, 10'h2AB);
    chk("R6 no irq", irq_flag, 0);
    repeat (3) tick1();

    // R6 abort during acquisition
    acq_sel = 3'd4;
    pulse_go();
    tick1(); tick1();
    pulse_clr();
    chk("R6 abort in acquisition", busy, 0);
    repeat (3) tick1();
    chk("R6 result kept after acq abort", {result_hi[1:0], result_lo}, 10'h2AB);

    // R9 / R10 / R11 triggers
    acq_sel = 0; vin = 10'h3A5;
    mode_sel = 4'b1010;
    pulse_trig();
    chk("R10 timer_rst wrong mode", timer_rst, 1);
    chk("R9 wrong mode ignored", busy, 0);
    @(negedge clk);
    chk("R10 timer_rst one clock", timer_rst, 0);
    enable = 0; mode_sel = 4'b1011;
    pulse_trig();
    chk("R10 timer_rst while disabled", timer_rst, 1);
    chk("R9 disabled ignored", busy, 0);
    pulse_go();
    chk("R11 go_set disabled", busy, 0);
    tick1();
    chk("R11 no conversion", hold_conn, 1);
    enable = 1;
    pulse_trig();
    chk("R9 valid trigger starts", busy, 1);
    chk("R10 timer_rst valid", timer_rst, 1);
    ticks_to_done(n);
    chk("R9 triggered conversion ticks", n, 12);
    chk("R9 triggered result", {result_hi[1:0], result_lo}, 10'h3A5);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule